// File: doc/BRIEF.md
# Dual-Channel LED PWM Dimmer

This block drives two active-low, open-drain style output levels for indicator LEDs. Each channel normally mirrors one data bit of the most recent data call: a set bit lights the LED by pulling the pin low. When the PWM feature flag is on, a lit channel is also gated by a pulse-width waveform, so its LED can be dimmed to one of four brightness steps.

Brightness is programmed through a 4-bit parameter value taken from a write-parameter call. One bit of the value picks the channel and the two lowest bits pick a binary-weighted on-ratio. A new ratio is held pending until the strobe reporting that the reply to that call has left the slave arrives. It then takes effect at the next PWM period boundary, so no shortened or stretched pulse appears on the pin. A second flag switches the PWM repetition rate between a slow 125 Hz and a fast 32 kHz. Both rates are derived from the system clock by a prescaler.

Top module: `led_pwm_dimmer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both pins are high (LED off). After reset both channels run at the full 16/16 on-ratio.
- R2: With the PWM flag low, each pin equals the inverse of its data bit, one clock after the data bit is sampled. Channel 0 follows `dataI0` and channel 1 follows `dataI1`.
- R3: A data bit of 0 keeps its pin high in every cycle, whatever the PWM settings are.
- R4: With the PWM flag high and the data bit at 1, a channel is low for N of the 16 slots of every period. The slots are the first N of the period. N comes from parameter bits [1:0]: 11 gives 16, 01 gives 8, 10 gives 4, and 00 gives 2.
- R5: Parameter bit 2 selects the target channel: 1 selects channel 0 and 0 selects channel 1. The channel not selected keeps its ratio. Parameter bit 3 is ignored.
- R6: With `fastMode` at 1 one PWM period lasts CLK_HZ/FAST_HZ clocks, and with `fastMode` at 0 it lasts CLK_HZ/SLOW_HZ clocks. These are 32 and 128 clocks at CLK_HZ=16000, FAST_HZ=500, SLOW_HZ=125.
- R7: A received ratio does not affect the pins until `respSent` has pulsed after it. A parameter strobe is never applied in the clock that follows it.
- R8: A pending ratio is applied only at the end of a PWM period. Every low pulse on a pin therefore has the full length of either the old or the new ratio.
- R9: If a second parameter strobe arrives before the pending ratio is applied, it replaces the first one. Only the later value takes effect after `respSent`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dataI0 | input | 1 | Data bit for channel 0 (1 = LED on) |
| dataI1 | input | 1 | Data bit for channel 1 (1 = LED on) |
| pwmEnable | input | 1 | Enables PWM gating of lit channels |
| fastMode | input | 1 | 1 selects the 32 kHz rate, 0 selects the 125 Hz rate |
| paramStb | input | 1 | One-cycle strobe, write-parameter value valid |
| paramVal | input | 4 | Parameter value: bit 2 is the channel, bits [1:0] are the ratio code |
| respSent | input | 1 | One-cycle strobe, reply to the last call has been sent |
| ledPin0 | output | 1 | Channel 0 pin level (0 = LED on) |
| ledPin1 | output | 1 | Channel 1 pin level (0 = LED on) |

## Verification
Several properties are checked on every cycle: pins stay off when the data bit is low, pins follow the inverted data bits when PWM is off, pins are off right after reset, no ratio is applied in the cycle after a parameter strobe, and every ratio update falls on a period boundary. Only the bench scenarios can show the rest. These are the on-time of each code measured over whole periods at both rates, the channel mapping of parameter bit 2, the hold until the reply strobe, the replacement of one pending value by another, and the absence of truncated pulses when the ratio changes.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;

  // Ratio update command passed from control to datapath
  typedef struct packed {
    logic       load;   // apply strobe, one cycle
    logic       chIdx;  // 0 = channel 0, 1 = channel 1
    logic [1:0] code;   // ratio code
  } duty_cmd_t;

  localparam logic [1:0] CODE_FULL = 2'b11;

  // Slots lit per period for a ratio code, for a period of 'slots' slots
  function automatic int unsigned litSlots(input logic [1:0] code, input int unsigned slots);
    case (code)
      2'b11:   return slots;
      2'b01:   return slots / 2;
      2'b10:   return slots / 4;
      default: return slots / 8;
    endcase
  endfunction

endpackage

// File: rtl/dimmer_ctrl.sv
module dimmer_ctrl
  import dimmer_pkg::*;
#(
  parameter int PARAM_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               paramStb,
  input  logic [PARAM_W-1:0] paramVal,
  input  logic               respSent,
  input  logic               periodEnd,
  output duty_cmd_t          dutyCmd
);

  logic       pendValid;
  logic       armed;
  logic       pendCh;
  logic [1:0] pendCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      armed     <= 1'b0;
      pendCh    <= 1'b0;
      pendCode  <= CODE_FULL;
    end else if (paramStb) begin
      // newest value wins; must wait for its own reply
      pendValid <= 1'b1;
      armed     <= 1'b0;
      pendCh    <= ~paramVal[2];
      pendCode  <= paramVal[1:0];
    end else if (dutyCmd.load) begin
      pendValid <= 1'b0;
      armed     <= 1'b0;
    end else if (respSent && pendValid) begin
      armed     <= 1'b1;
    end
  end

  always_comb begin
    dutyCmd.load  = armed & periodEnd;
    dutyCmd.chIdx = pendCh;
    dutyCmd.code  = pendCode;
  end

endmodule

// File: rtl/dimmer_datapath.sv
module dimmer_datapath
  import dimmer_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int SLOW_DIV = 8000,
  parameter int FAST_DIV = 31
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fastMode,
  input  logic      pwmEnable,
  input  logic      dataI0,
  input  logic      dataI1,
  input  duty_cmd_t dutyCmd,
  output logic      periodEnd,
  output logic      ledPin0,
  output logic      ledPin1
);

  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int LIT_W   = SLOT_W + 1;
  localparam int CH_N    = 2;

  logic [DIV_W-1:0]  preCnt;
  logic [DIV_W-1:0]  divLast;
  logic              slotTick;
  logic [SLOT_W-1:0] slotCnt;
  logic [CH_N-1:0]   dataBits;
  logic [CH_N-1:0]   pinReg;

  assign divLast  = fastMode ? DIV_W'(FAST_DIV - 1) : DIV_W'(SLOW_DIV - 1);
  assign slotTick = (preCnt >= divLast);
  assign periodEnd = slotTick && (slotCnt == SLOT_W'(SLOTS - 1));

  // Prescaler; '>=' recovers cleanly when the rate is switched down
  always_ff @(posedge clk) begin
    if (rst)           preCnt <= '0;
    else if (slotTick) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           slotCnt <= '0;
    else if (slotTick) slotCnt <= (slotCnt == SLOT_W'(SLOTS - 1)) ? '0 : slotCnt + 1'b1;
  end

  assign dataBits = {dataI1, dataI0};

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    logic [1:0]       dutyCode;
    logic [LIT_W-1:0] litN;
    logic             inWindow;

    always_ff @(posedge clk) begin
      if (rst)
        dutyCode <= CODE_FULL;
      else if (dutyCmd.load && (dutyCmd.chIdx == 1'(ch)))
        dutyCode <= dutyCmd.code;
    end

    assign litN     = LIT_W'(litSlots(dutyCode, SLOTS));
    assign inWindow = ({1'b0, slotCnt} < litN);

    always_ff @(posedge clk) begin
      if (rst) pinReg[ch] <= 1'b1;
      else     pinReg[ch] <= ~(dataBits[ch] & (~pwmEnable | inWindow));
    end
  end

  assign ledPin0 = pinReg[0];
  assign ledPin1 = pinReg[1];

endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
  import dimmer_pkg::*;
#(
  parameter int CLK_HZ  = 16_000_000,
  parameter int SLOW_HZ = 125,
  parameter int FAST_HZ = 32_000,
  parameter int SLOTS   = 16,
  parameter int PARAM_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dataI0,
  input  logic               dataI1,
  input  logic               pwmEnable,
  input  logic               fastMode,
  input  logic               paramStb,
  input  logic [PARAM_W-1:0] paramVal,
  input  logic               respSent,
  output logic               ledPin0,
  output logic               ledPin1
);

  localparam int SLOW_DIV = CLK_HZ / (SLOW_HZ * SLOTS);
  localparam int FAST_DIV = CLK_HZ / (FAST_HZ * SLOTS);

  duty_cmd_t dutyCmd;
  logic      periodEnd;

  dimmer_ctrl #(.PARAM_W(PARAM_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .paramStb  (paramStb),
    .paramVal  (paramVal),
    .respSent  (respSent),
    .periodEnd (periodEnd),
    .dutyCmd   (dutyCmd)
  );

  dimmer_datapath #(
    .SLOTS    (SLOTS),
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .fastMode  (fastMode),
    .pwmEnable (pwmEnable),
    .dataI0    (dataI0),
    .dataI1    (dataI1),
    .dutyCmd   (dutyCmd),
    .periodEnd (periodEnd),
    .ledPin0   (ledPin0),
    .ledPin1   (ledPin1)
  );

endmodule

// File: rtl/dimmer_checker.sv
module dimmer_checker (
  input logic clk,
  input logic rst,
  input logic dataI0,
  input logic dataI1,
  input logic pwmEnable,
  input logic paramStb,
  input logic ledPin0,
  input logic ledPin1,
  input logic cmdLoad,
  input logic periodEnd
);

  AST_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ledPin0 && ledPin1)); // R1

  AST_PLAIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pwmEnable)) |-> ((ledPin0 == !$past(dataI0)) && (ledPin1 == !$past(dataI1)))); // R2

  AST_DATA_LOW_OFF0: assert property (@(posedge clk) disable iff (rst)
    !$past(dataI0) |-> ledPin0); // R3

  AST_DATA_LOW_OFF1: assert property (@(posedge clk) disable iff (rst)
    !$past(dataI1) |-> ledPin1); // R3

  AST_WAIT_FOR_REPLY: assert property (@(posedge clk) disable iff (rst)
    paramStb |=> !cmdLoad); // R7

  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    cmdLoad |-> periodEnd); // R8

endmodule

bind led_pwm_dimmer dimmer_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .dataI0    (dataI0),
  .dataI1    (dataI1),
  .pwmEnable (pwmEnable),
  .paramStb  (paramStb),
  .ledPin0   (ledPin0),
  .ledPin1   (ledPin1),
  .cmdLoad   (dutyCmd.load),
  .periodEnd (periodEnd)
);

// File: tb/led_pwm_dimmer_test.sv
module led_pwm_dimmer_test;

  localparam int SLOW_P = 128;  // clocks per period, slow rate
  localparam int FAST_P = 32;   // clocks per period, fast rate
  localparam int SETTLE = 2 * SLOW_P + 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataI0 = 1'b0, dataI1 = 1'b0;
  logic       pwmEnable = 1'b0, fastMode = 1'b0;
  logic       paramStb = 1'b0, respSent = 1'b0;
  logic [3:0] paramVal = 4'h0;
  logic       ledPin0, ledPin1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  led_pwm_dimmer #(.CLK_HZ(16000), .SLOW_HZ(125), .FAST_HZ(500)) uut (
    .clk(clk), .rst(rst), .dataI0(dataI0), .dataI1(dataI1),
    .pwmEnable(pwmEnable), .fastMode(fastMode), .paramStb(paramStb),
    .paramVal(paramVal), .respSent(respSent), .ledPin0(ledPin0), .ledPin1(ledPin1)
  );

  // param, fast, period, lit0, lit1 (per period)
  typedef struct packed {
    logic [3:0] pv;
    logic       fast;
    int         per;
    int         lit0;
    int         lit1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0101, 1'b0, SLOW_P, 64, 128},   // R4 R5: ch0 8/16
    '{4'b0010, 1'b0, SLOW_P, 64, 32},    // R4 R5: ch1 4/16
    '{4'b1100, 1'b1, FAST_P, 4, 8},      // R4 R5 R6: ch0 2/16, bit3 ignored
    '{4'b0011, 1'b1, FAST_P, 4, 32},     // R4 R6: ch1 16/16
    '{4'b0111, 1'b0, SLOW_P, 128, 128},  // R4: ch0 back to full
    '{4'b1000, 1'b0, SLOW_P, 128, 16}    // R4 R5: ch1 2/16
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendParam(input logic [3:0] v);
    paramVal = v; paramStb = 1'b1;
    tick(1);
    paramStb = 1'b0;
  endtask

  task automatic sendResp();
    respSent = 1'b1;
    tick(1);
    respSent = 1'b0;
  endtask

  task automatic countLit(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    repeat (n) begin
      @(negedge clk);
      if (!ledPin0) c0++;
      if (!ledPin1) c1++;
    end
    #1;
  endtask

  task automatic runLen0(output int len);
    int guard;
    len = 0; guard = 0;
    do begin @(negedge clk); guard++; end while (!ledPin0 && guard < 400);
    do begin @(negedge clk); guard++; end while (ledPin0 && guard < 800);
    while (!ledPin0 && len < 400) begin len++; @(negedge clk); end
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, c1, len;
    bit okRuns;
    // R1: pins off during reset even with data set
    dataI0 = 1'b1; dataI1 = 1'b1;
    tick(4);
    @(negedge clk);
    check("R1 reset pin0", ledPin0, 1);
    check("R1 reset pin1", ledPin1, 1);
    rst = 1'b0;
    #1;

    // R1: default full ratio with PWM on
    pwmEnable = 1'b1;
    tick(2);
    countLit(SLOW_P, c0, c1);
    check("R1 default ch0", c0, SLOW_P);
    check("R1 default ch1", c1, SLOW_P);

    // Vector table
    foreach (VECS[i]) begin
      fastMode = VECS[i].fast;
      sendParam(VECS[i].pv);
      sendResp();
      tick(SETTLE);
      countLit(VECS[i].per, c0, c1);
      check($sformatf("R4 vec%0d ch0", i), c0, VECS[i].lit0);
      check($sformatf("R5 vec%0d ch1", i), c1, VECS[i].lit1);
    end

    // R6: run length of 8/16 at both rates
    sendParam(4'b0101); sendResp();
    fastMode = 1'b1; tick(SETTLE);
    runLen0(len);
    check("R6 fast run", len, FAST_P / 2);
    fastMode = 1'b0; tick(SETTLE);
    runLen0(len);
    check("R6 slow run", len, SLOW_P / 2);

    // R3: data low keeps pin off under PWM
    dataI0 = 1'b0;
    tick(2);
    countLit(SLOW_P, c0, c1);
    check("R3 ch0 data low", c0, 0);
    dataI0 = 1'b1;

    // R2: PWM off, pins follow inverted data
    pwmEnable = 1'b0;
    dataI0 = 1'b1; dataI1 = 1'b0;
    tick(2);
    check("R2 pin0", ledPin0, 0);
    check("R2 pin1", ledPin1, 1);
    dataI0 = 1'b0; dataI1 = 1'b1;
    tick(2);
    check("R2 pin0 b", ledPin0, 1);
    check("R2 pin1 b", ledPin1, 0);
    dataI0 = 1'b1; pwmEnable = 1'b1;

    // R7: no reply, no change (ch0 stays 8/16)
    sendParam(4'b0100);
    tick(SETTLE);
    countLit(SLOW_P, c0, c1);
    check("R7 held ch0", c0, 64);
    sendResp();
    tick(SETTLE);
    countLit(SLOW_P, c0, c1);
    check("R7 applied ch0", c0, 16);

    // R9: later value replaces pending one
    sendParam(4'b0110);
    sendParam(4'b0111);
    sendResp();
    tick(SETTLE);
    countLit(SLOW_P, c0, c1);
    check("R9 last wins ch0", c0, SLOW_P);

    // R8: from 2/16 to 8/16, every pulse whole
    sendParam(4'b0100); sendResp(); tick(SETTLE);
    sendParam(4'b0101); sendResp();
    okRuns = 1'b1;
    for (int k = 0; k < 4; k++) begin
      runLen0(len);
      if (len != 16 && len != 64) okRuns = 1'b0;
    end
    check("R8 whole pulses", okRuns, 1);
    check("R8 final run", len, 64);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule